// File: doc/BRIEF.md
# Banker's Safety State Checker

This block decides whether a resource-allocation snapshot can always be driven to completion. It holds a small fixed set of processes and resource types: a vector of free instances per resource type, a per-process matrix of instances already held, and a per-process matrix of declared maximum claims. The remaining demand of each process is computed from the last two and is never stored. A host fills these registers through a single-entry write port while the block is idle.

A start pulse launches a sequential search. The search begins with a working vector equal to the free vector and no process marked complete. In each cycle it retires at most one process whose remaining demand fits inside the working vector, and adds that process's held instances back into the working vector. When no candidate is left, a done pulse reports a safe flag and the completion order. A request pulse names one process and a demand vector. Such a request is rejected at once as an error or as a wait. Otherwise it is tried on a tentative view of the state. If that view is safe, the request is granted and committed. If it is unsafe, the request is answered with wait and the stored state stays as it was.

Top module: `bk_safety_top`

## Requirements
- R1: Remaining demand of process p for type r is max[p][r] − held[p][r]. The host loads one element per cycle with wr_sel encoding 0 = free vector (index wr_res), 1 = held matrix, 2 = max matrix, 3 = no effect. Indices out of range are dropped.
- R2: A search starts from working = free vector and all processes unfinished. Each cycle, of all unfinished processes whose remaining demand is ≤ working in every type, the lowest-index one finishes and its held vector is added to working. The k-th finishing process index appears in order_o slot k, at bits [k*PW +: PW], where slot 0 is first.
- R3: A search that finishes n processes raises done_o for one cycle after n+1 clock edges following acceptance. busy_o is high from the edge of acceptance until that done edge, so it never exceeds NPROC+1 cycles.
- R4: safe_o is 1 exactly when every process finished. safe_o, order_o and order_len_o (the number finished) change only at the done of a search, and they hold otherwise. Order slots at or after order_len_o read 0.
- R5: A request with req_proc ≥ NPROC, or with any element greater than that process's remaining demand, gives resp_o = 3 (error) with done_o one edge later. The stored state is unchanged and no search runs.
- R6: A request that passes R5 but has any element greater than the free vector gives resp_o = 2 (wait) with done_o one edge later. The state is unchanged.
- R7: Any other request runs a search on the tentative state (free − req, held[p] + req). If that search is safe, resp_o = 1 (grant) and the stored state becomes the tentative state.
- R8: If the tentative search is unsafe, resp_o = 2 (wait) and the stored free vector and held matrix are exactly as before the request.
- R9: While busy_o is high, wr_en_i, start_i and req_valid_i have no effect. A write presented in the same cycle as an accepted start or request is also dropped.
- R10: After reset, busy_o, done_o, safe_o, resp_o, order_o and order_len_o are 0 and all stored counts are 0.
- R11: When start_i and req_valid_i are both high while idle, the start is taken. A plain search reports resp_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Target: 0 free, 1 held, 2 max |
| wr_proc_i | input | PW | Process index for matrix writes |
| wr_res_i | input | RW | Resource type index |
| wr_data_i | input | CW | Count written |
| start_i | input | 1 | Launch safety search on stored state |
| req_valid_i | input | 1 | Present a request |
| req_proc_i | input | PW | Requesting process |
| req_vec_i | input | NRES*CW | Request, type r at [r*CW +: CW] |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| safe_o | output | 1 | Last search ended with all finished |
| resp_o | output | 2 | 0 none, 1 grant, 2 wait, 3 error |
| order_o | output | NPROC*PW | Completion order, slot k at [k*PW +: PW] |
| order_len_o | output | SW | Processes finished in last search |

## Verification
The hardest situation to reach is a request that passes both immediate checks and is then refused by the tentative search. Confirming that nothing was committed needs a second search afterwards, so that the stored free vector and held matrix show up again in the reported order. The stimulus loads a known safe snapshot and grants one request that shrinks the free vector. It then issues a demand that fits the free vector but starves every other process, and runs a plain search right after. Randomised snapshots with small counts add ties between several eligible processes and partial completions. The reference model in the bench resolves each tie by lowest index on its own.

// File: rtl/bk_pkg.sv
package bk_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_SEARCH = 1'b1} bk_state_e;

  localparam logic [1:0] RSP_NONE  = 2'd0;
  localparam logic [1:0] RSP_GRANT = 2'd1;
  localparam logic [1:0] RSP_WAIT  = 2'd2;
  localparam logic [1:0] RSP_ERR   = 2'd3;
endpackage

// File: rtl/bk_store.sv
// Holds free vector, held matrix and max matrix (R1), with commit path (R7).
module bk_store #(
  parameter int NPROC = 5,
  parameter int NRES  = 3,
  parameter int CW    = 4,
  parameter int PW    = 3,
  parameter int RW    = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_sel_i,
  input  logic [PW-1:0]            wr_proc_i,
  input  logic [RW-1:0]            wr_res_i,
  input  logic [CW-1:0]            wr_data_i,
  input  logic                     cm_en_i,
  input  logic [PW-1:0]            cm_proc_i,
  input  logic [NRES*CW-1:0]       cm_vec_i,
  output logic [NRES*CW-1:0]       free_o,
  output logic [NPROC*NRES*CW-1:0] held_o,
  output logic [NPROC*NRES*CW-1:0] max_o
);
  logic [CW-1:0] free_q [NRES];
  logic [CW-1:0] held_q [NPROC][NRES];
  logic [CW-1:0] max_q  [NPROC][NRES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int r = 0; r < NRES; r++) begin
        free_q[r] <= '0;
        for (int p = 0; p < NPROC; p++) begin
          held_q[p][r] <= '0;
          max_q[p][r]  <= '0;
        end
      end
    end else begin
      if (wr_en_i) begin
        for (int r = 0; r < NRES; r++) begin
          if (RW'(r) == wr_res_i) begin
            if (wr_sel_i == 2'd0) free_q[r] <= wr_data_i;
            for (int p = 0; p < NPROC; p++) begin
              if (PW'(p) == wr_proc_i) begin
                if (wr_sel_i == 2'd1) held_q[p][r] <= wr_data_i;
                if (wr_sel_i == 2'd2) max_q[p][r]  <= wr_data_i;
              end
            end
          end
        end
      end
      if (cm_en_i) begin
        for (int r = 0; r < NRES; r++) begin
          free_q[r] <= free_q[r] - cm_vec_i[r*CW +: CW];
          for (int p = 0; p < NPROC; p++) begin
            if (PW'(p) == cm_proc_i)
              held_q[p][r] <= held_q[p][r] + cm_vec_i[r*CW +: CW];
          end
        end
      end
    end
  end

  generate
    for (genvar r = 0; r < NRES; r++) begin : g_free
      assign free_o[r*CW +: CW] = free_q[r];
      for (genvar p = 0; p < NPROC; p++) begin : g_mat
        assign held_o[(p*NRES+r)*CW +: CW] = held_q[p][r];
        assign max_o[(p*NRES+r)*CW +: CW]  = max_q[p][r];
      end
    end
  endgenerate
endmodule

// File: rtl/bk_pick.sv
// Lowest-index unfinished process whose demand fits the working vector (R2).
module bk_pick #(
  parameter int NPROC = 5,
  parameter int NRES  = 3,
  parameter int CW    = 4,
  parameter int WW    = 7,
  parameter int PW    = 3
) (
  input  logic [NPROC*NRES*CW-1:0] need_i,
  input  logic [NRES*WW-1:0]       work_i,
  input  logic [NPROC-1:0]         fin_i,
  output logic                     found_o,
  output logic [PW-1:0]            idx_o
);
  logic [NPROC-1:0] elig;

  generate
    for (genvar p = 0; p < NPROC; p++) begin : g_elig
      logic fits;
      always_comb begin
        fits = 1'b1;
        for (int r = 0; r < NRES; r++) begin
          if ({{(WW-CW){1'b0}}, need_i[(p*NRES+r)*CW +: CW]} > work_i[r*WW +: WW])
            fits = 1'b0;
        end
      end
      assign elig[p] = fits & ~fin_i[p];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int p = NPROC - 1; p >= 0; p--) begin
      if (elig[p]) idx_o = PW'(p);
    end
  end

  assign found_o = |elig;
endmodule

// File: rtl/bk_safety_top.sv
module bk_safety_top
  import bk_pkg::*;
#(
  parameter int NPROC = 5,
  parameter int NRES  = 3,
  parameter int CW    = 4,
  parameter int PW    = (NPROC > 1) ? $clog2(NPROC) : 1,
  parameter int RW    = (NRES > 1) ? $clog2(NRES) : 1,
  parameter int SW    = $clog2(NPROC + 1)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [PW-1:0]       wr_proc_i,
  input  logic [RW-1:0]       wr_res_i,
  input  logic [CW-1:0]       wr_data_i,
  input  logic                start_i,
  input  logic                req_valid_i,
  input  logic [PW-1:0]       req_proc_i,
  input  logic [NRES*CW-1:0]  req_vec_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                safe_o,
  output logic [1:0]          resp_o,
  output logic [NPROC*PW-1:0] order_o,
  output logic [SW-1:0]       order_len_o
);
  localparam int WW = CW + PW;

  bk_state_e                 state_q;
  logic                      tent_q;
  logic [PW-1:0]             tproc_q;
  logic [NRES*CW-1:0]        treq_q;
  logic [NRES*WW-1:0]        work_q, work_n, work_init;
  logic [NPROC-1:0]          fin_q, fin_n;
  logic [SW-1:0]             step_q;
  logic [NPROC*PW-1:0]       ord_q, ord_n;

  logic [NRES*CW-1:0]        free_w;
  logic [NPROC*NRES*CW-1:0]  held_w, max_w, need_v, held_v;
  logic                      found;
  logic [PW-1:0]             pick;
  logic                      over_need, over_free, idle, wr_ok, commit;

  assign idle  = (state_q == ST_IDLE);
  assign wr_ok = wr_en_i & idle & ~start_i & ~req_valid_i;            // R9
  assign commit = (state_q == ST_SEARCH) & ~found & tent_q & (&fin_q); // R7

  bk_store #(.NPROC(NPROC), .NRES(NRES), .CW(CW), .PW(PW), .RW(RW)) u_store (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_ok), .wr_sel_i(wr_sel_i), .wr_proc_i(wr_proc_i),
    .wr_res_i(wr_res_i), .wr_data_i(wr_data_i),
    .cm_en_i(commit), .cm_proc_i(tproc_q), .cm_vec_i(treq_q),
    .free_o(free_w), .held_o(held_w), .max_o(max_w)
  );

  // Tentative view: the requesting row sees held + req during a trial (R7, R8)
  always_comb begin
    for (int p = 0; p < NPROC; p++) begin
      for (int r = 0; r < NRES; r++) begin
        held_v[(p*NRES+r)*CW +: CW] = held_w[(p*NRES+r)*CW +: CW] +
          ((tent_q && PW'(p) == tproc_q) ? treq_q[r*CW +: CW] : '0);
        need_v[(p*NRES+r)*CW +: CW] = max_w[(p*NRES+r)*CW +: CW] -
          held_v[(p*NRES+r)*CW +: CW];
      end
    end
  end

  bk_pick #(.NPROC(NPROC), .NRES(NRES), .CW(CW), .WW(WW), .PW(PW)) u_pick (
    .need_i(need_v), .work_i(work_q), .fin_i(fin_q),
    .found_o(found), .idx_o(pick)
  );

  // Immediate request screening (R5, R6)
  always_comb begin
    over_need = ({1'b0, req_proc_i} >= (PW+1)'(NPROC));
    over_free = 1'b0;
    for (int r = 0; r < NRES; r++) begin
      if (req_vec_i[r*CW +: CW] > free_w[r*CW +: CW]) over_free = 1'b1;
      for (int p = 0; p < NPROC; p++) begin
        if (PW'(p) == req_proc_i &&
            req_vec_i[r*CW +: CW] > (max_w[(p*NRES+r)*CW +: CW] - held_w[(p*NRES+r)*CW +: CW]))
          over_need = 1'b1;
      end
    end
  end

  // Next working vector, finish set and order for one search step (R2)
  always_comb begin
    work_n = work_q;
    fin_n  = fin_q;
    ord_n  = ord_q;
    for (int p = 0; p < NPROC; p++) begin
      if (PW'(p) == pick) begin
        fin_n[p] = 1'b1;
        for (int r = 0; r < NRES; r++)
          work_n[r*WW +: WW] = work_q[r*WW +: WW] +
            {{(WW-CW){1'b0}}, held_v[(p*NRES+r)*CW +: CW]};
      end
    end
    for (int k = 0; k < NPROC; k++) begin
      if (SW'(k) == step_q) ord_n[k*PW +: PW] = pick;
    end
    for (int r = 0; r < NRES; r++)
      work_init[r*WW +: WW] = {{(WW-CW){1'b0}}, free_w[r*CW +: CW]} -
        (req_valid_i && !start_i ? {{(WW-CW){1'b0}}, req_vec_i[r*CW +: CW]} : '0);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q     <= ST_IDLE;
      tent_q      <= 1'b0;
      tproc_q     <= '0;
      treq_q      <= '0;
      work_q      <= '0;
      fin_q       <= '0;
      step_q      <= '0;
      ord_q       <= '0;
      done_o      <= 1'b0;
      safe_o      <= 1'b0;
      resp_o      <= RSP_NONE;
      order_o     <= '0;
      order_len_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i || (req_valid_i && !over_need && !over_free)) begin
            state_q <= ST_SEARCH;                // R11: start wins
            tent_q  <= ~start_i;
            tproc_q <= req_proc_i;
            treq_q  <= req_vec_i;
            work_q  <= work_init;
            fin_q   <= '0;
            step_q  <= '0;
            ord_q   <= '0;
          end else if (req_valid_i) begin
            done_o <= 1'b1;
            resp_o <= over_need ? RSP_ERR : RSP_WAIT;
          end
        end
        default: begin
          if (found) begin
            work_q <= work_n;
            fin_q  <= fin_n;
            ord_q  <= ord_n;
            step_q <= step_q + 1'b1;
          end else begin
            state_q     <= ST_IDLE;
            done_o      <= 1'b1;
            safe_o      <= &fin_q;
            order_o     <= ord_q;
            order_len_o <= step_q;
            resp_o      <= !tent_q ? RSP_NONE : ((&fin_q) ? RSP_GRANT : RSP_WAIT);
            tent_q      <= 1'b0;
          end
        end
      endcase
    end
  end

  assign busy_o = (state_q == ST_SEARCH);
endmodule

// File: rtl/bk_safety_chk.sv
module bk_safety_chk #(
  parameter int NPROC = 5,
  parameter int PW    = 3,
  parameter int SW    = 3
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                start_i,
  input logic                req_valid_i,
  input logic                busy_o,
  input logic                done_o,
  input logic                safe_o,
  input logic [1:0]          resp_o,
  input logic [NPROC*PW-1:0] order_o,
  input logic [SW-1:0]       order_len_o
);
  localparam int CNTW = $clog2(NPROC + 3) + 1;
  logic [CNTW-1:0] busy_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i || !busy_o) busy_cnt <= '0;
    else                  busy_cnt <= busy_cnt + 1'b1;
  end

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !busy_o);

  assert_busy_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_cnt <= CNTW'(NPROC + 1));

  assert_start_taken_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o) |=> busy_o);

  assert_req_answered_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_valid_i && !busy_o) |=> (busy_o || done_o));

  assert_grant_safe_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && resp_o == 2'd1) |-> (safe_o && order_len_o == SW'(NPROC)));

  assert_safe_full_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    safe_o |-> (order_len_o == SW'(NPROC)));

  assert_order_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_o |-> ($stable(order_o) && $stable(safe_o) && $stable(order_len_o)));
endmodule

bind bk_safety_top bk_safety_chk #(.NPROC(NPROC), .PW(PW), .SW(SW)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .req_valid_i(req_valid_i),
  .busy_o(busy_o), .done_o(done_o), .safe_o(safe_o), .resp_o(resp_o),
  .order_o(order_o), .order_len_o(order_len_o)
);

// File: tb/bk_safety_top_tb.sv
`timescale 1ns/1ps
module bk_safety_top_tb_top;
  localparam int NPROC = 5, NRES = 3, CW = 4, PW = 3, RW = 2, SW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, start = 0, req_valid = 0;
  logic [1:0] wr_sel = 0;
  logic [PW-1:0] wr_proc = 0, req_proc = 0;
  logic [RW-1:0] wr_res = 0;
  logic [CW-1:0] wr_data = 0;
  logic [NRES*CW-1:0] req_vec = 0;
  logic busy, done, safe;
  logic [1:0] resp;
  logic [NPROC*PW-1:0] order;
  logic [SW-1:0] order_len;

  always #2 clk = ~clk;

  bk_safety_top dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_proc_i(wr_proc), .wr_res_i(wr_res), .wr_data_i(wr_data),
    .start_i(start), .req_valid_i(req_valid), .req_proc_i(req_proc),
    .req_vec_i(req_vec), .busy_o(busy), .done_o(done), .safe_o(safe),
    .resp_o(resp), .order_o(order), .order_len_o(order_len)
  );

  int errors = 0, checks = 0;
  string tag = "R10";
  bit finished = 0;

  // Behavioural reference model
  int m_av[NRES], m_al[NPROC][NRES], m_mx[NPROC][NRES];
  int s_av[NRES], s_al[NPROC][NRES], s_mx[NPROC][NRES];
  int p_ord[NPROC], e_ord[NPROC], p_len, e_len, p_resp, e_resp, m_left, p_proc;
  int p_req[NRES];
  bit p_safe, e_safe, e_done, m_busy, p_commit;

  task automatic sim_search();
    int w[NRES];
    bit f[NPROC];
    bit ok, prog;
    int n = 0;
    for (int r = 0; r < NRES; r++) w[r] = s_av[r];
    for (int p = 0; p < NPROC; p++) f[p] = 0;
    prog = 1;
    while (prog) begin
      prog = 0;
      for (int p = 0; p < NPROC && !prog; p++) begin
        if (!f[p]) begin
          ok = 1;
          for (int r = 0; r < NRES; r++) if (s_mx[p][r] - s_al[p][r] > w[r]) ok = 0;
          if (ok) begin
            for (int r = 0; r < NRES; r++) w[r] += s_al[p][r];
            f[p] = 1; p_ord[n] = p; n++; prog = 1;
          end
        end
      end
    end
    for (int k = n; k < NPROC; k++) p_ord[k] = 0;
    p_len = n;
    p_safe = (n == NPROC);
  endtask

  task automatic snap();
    for (int r = 0; r < NRES; r++) begin
      s_av[r] = m_av[r];
      for (int p = 0; p < NPROC; p++) begin s_al[p][r] = m_al[p][r]; s_mx[p][r] = m_mx[p][r]; end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; e_done = 0; e_safe = 0; e_resp = 0; e_len = 0;
      for (int p = 0; p < NPROC; p++) begin
        e_ord[p] = 0;
        for (int r = 0; r < NRES; r++) begin m_al[p][r] = 0; m_mx[p][r] = 0; end
      end
      for (int r = 0; r < NRES; r++) m_av[r] = 0;
    end else begin
      e_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; e_done = 1; e_safe = p_safe; e_len = p_len; e_resp = p_resp;
          for (int k = 0; k < NPROC; k++) e_ord[k] = p_ord[k];
          if (p_commit)
            for (int r = 0; r < NRES; r++) begin
              m_av[r] -= p_req[r]; m_al[p_proc][r] += p_req[r];
            end
        end
      end else if (start) begin
        snap(); sim_search();
        p_resp = 0; p_commit = 0; m_busy = 1; m_left = p_len + 1;
      end else if (req_valid) begin
        bit err, wt;
        p_proc = int'(req_proc);
        err = (p_proc >= NPROC); wt = 0;
        for (int r = 0; r < NRES; r++) begin
          p_req[r] = int'(req_vec[r*CW +: CW]);
          if (!err && p_req[r] > m_mx[p_proc][r] - m_al[p_proc][r]) err = 1;
        end
        if (!err) for (int r = 0; r < NRES; r++) if (p_req[r] > m_av[r]) wt = 1;
        if (err) begin e_resp = 3; e_done = 1; end
        else if (wt) begin e_resp = 2; e_done = 1; end
        else begin
          snap();
          for (int r = 0; r < NRES; r++) begin s_av[r] -= p_req[r]; s_al[p_proc][r] += p_req[r]; end
          sim_search();
          p_commit = p_safe; p_resp = p_safe ? 1 : 2; m_busy = 1; m_left = p_len + 1;
        end
      end else if (wr_en) begin
        if (int'(wr_res) < NRES) begin
          if (wr_sel == 0) m_av[wr_res] = int'(wr_data);
          else if (int'(wr_proc) < NPROC && wr_sel == 1) m_al[wr_proc][wr_res] = int'(wr_data);
          else if (int'(wr_proc) < NPROC && wr_sel == 2) m_mx[wr_proc][wr_res] = int'(wr_data);
        end
      end
    end
  end

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("busy", int'(busy), int'(m_busy));
      chk("done", int'(done), int'(e_done));
      chk("safe", int'(safe), int'(e_safe));
      chk("resp", int'(resp), e_resp);
      chk("order_len", int'(order_len), e_len);
      for (int k = 0; k < NPROC; k++) chk("order slot", int'(order[k*PW +: PW]), e_ord[k]);
    end
  end

  task automatic wr(input int sel, input int p, input int r, input int d);
    wr_en = 1; wr_sel = 2'(sel); wr_proc = PW'(p); wr_res = RW'(r); wr_data = CW'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_row(input int sel, input int p, input int a, input int b, input int c);
    wr(sel, p, 0, a); wr(sel, p, 1, b); wr(sel, p, 2, c);
  endtask

  task automatic go();
    start = 1; @(negedge clk); start = 0;
    repeat (NPROC + 3) @(negedge clk);
  endtask

  task automatic ask(input int p, input int a, input int b, input int c);
    req_valid = 1; req_proc = PW'(p);
    req_vec = {CW'(c), CW'(b), CW'(a)};
    @(negedge clk); req_valid = 0;
    repeat (NPROC + 3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R10"; repeat (2) @(negedge clk);

    tag = "R1/R2";
    wr_row(0, 0, 3, 3, 2); wr(0, 0, 3, 9);           // index 3 dropped
    wr_row(1, 0, 0, 1, 0); wr_row(1, 1, 2, 0, 0); wr_row(1, 2, 3, 0, 2);
    wr_row(1, 3, 2, 1, 1); wr_row(1, 4, 0, 0, 2);
    wr_row(2, 0, 7, 5, 3); wr_row(2, 1, 3, 2, 2); wr_row(2, 2, 9, 0, 2);
    wr_row(2, 3, 2, 2, 2); wr_row(2, 4, 4, 3, 3);
    wr(3, 0, 0, 15);                                  // sel 3 no effect
    tag = "R2/R3/R4"; go();

    tag = "R7"; ask(1, 1, 0, 2);
    tag = "R7 state"; go();
    tag = "R6"; ask(4, 3, 3, 0);
    tag = "R8"; ask(0, 0, 2, 0);
    tag = "R8 state"; go();
    tag = "R5"; ask(3, 1, 0, 0);
    tag = "R5 proc"; ask(6, 0, 0, 0);

    tag = "R9";
    start = 1; @(negedge clk); start = 0;
    wr_en = 1; wr_sel = 0; wr_res = 0; wr_data = 15; start = 1; req_valid = 1;
    req_proc = 0; req_vec = '0;
    @(negedge clk); wr_en = 0; start = 0; req_valid = 0;
    repeat (NPROC + 3) @(negedge clk);
    tag = "R9 same-cycle"; wr_en = 1; wr_sel = 0; wr_res = 1; wr_data = 0; start = 1;
    @(negedge clk); wr_en = 0; start = 0; repeat (NPROC + 3) @(negedge clk);
    tag = "R9 state"; go();

    tag = "R11";
    start = 1; req_valid = 1; req_proc = 1; req_vec = {CW'(0), CW'(0), CW'(1)};
    @(negedge clk); start = 0; req_valid = 0; repeat (NPROC + 3) @(negedge clk);

    tag = "R4 unsafe";
    wr_row(0, 0, 0, 0, 0); go();

    for (int it = 0; it < 20; it++) begin
      tag = "R2/R7/R8 random";
      for (int p = 0; p < NPROC; p++) begin
        int a0, a1, a2;
        a0 = $urandom_range(0, 3); a1 = $urandom_range(0, 3); a2 = $urandom_range(0, 3);
        wr_row(1, p, a0, a1, a2);
        wr_row(2, p, a0 + $urandom_range(0, 4), a1 + $urandom_range(0, 4), a2 + $urandom_range(0, 4));
      end
      wr_row(0, 0, $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6));
      go();
      ask($urandom_range(0, NPROC - 1), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
      go();
    end
    finish_run();
  end
endmodule